// File: doc/BRIEF.md
# Glitch-free enabled clock divider

This block derives a slower clock from a master clock by an integer ratio N, chosen from 1 to 32. An output-enable input that may change at any time relative to the master clock starts and stops the derived clock. The enable is brought into the master-clock domain before it has any effect. Every change of state is tied to a period boundary of the divider, so the output only ever carries whole high and low phases.

For N of 2 or more the output comes from a register. Its high phase lasts ceil(N/2) master cycles and its low phase floor(N/2) cycles. A period that has started always runs to its end. Whether another period follows is decided only at the terminal count. For N equal to 1 the output is the master clock passed through a latch-based gate. The latch is transparent only while the master clock is low, so a pass-through pulse is never cut short.

Ratio values are clamped: 0 acts as 1 and anything above 32 acts as 32.

Top module: `glitchfree_clkdiv`

## Requirements
- R1: While rst_ni is low the output is low. After release the output stays low until an enable has crossed the synchronizer.
- R2: For N from 2 to 32 the enabled output repeats every N master cycles. Each period is high for ceil(N/2) cycles and then low for floor(N/2) cycles.
- R3: For N of 2 or more, an enable rise placed ahead of master rising edge 1 makes the output rise at edge 3 and not before. A period only starts while the synchronized enable is high.
- R4: The first period after enabling starts from count zero, so its high phase has the full ceil(N/2) width.
- R5: If enable falls while the output is high, that high phase completes at full width. Its low phase completes, and no further pulse follows.
- R6: A new period starts at a terminal-count edge only if enable was captured high on the master edge two edges earlier. If enable falls during the last low cycle before a terminal edge, exactly one more full period appears.
- R7: A ratio change made while the output runs takes effect at the next terminal count. The value in use while idle follows div_i. Value 0 acts as 1 and values above 32 act as 32.
- R8: For N equal to 1 the output equals the master clock while enabled and is low whenever the master clock is low. An enable rise captured at edge k gives the first pulse at edge k+1. An enable fall captured at edge k leaves the pulse of edge k as the last.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| div_i | input | 6 | Divide ratio N (0 acts as 1, above 32 acts as 32) |
| en_i | input | 1 | Output enable, asynchronous to clk_i |
| clk_o | output | 1 | Gated divided clock |

## Verification
The properties assume that reset is applied from time zero and that the ratio in use changes only at a terminal count, which the design enforces itself. They also assume the only switches between N equal to 1 and larger ratios happen at those boundaries, so the pulse-width counters can skip periods run at ratio 1. The bench changes en_i and div_i only shortly after a falling master edge, well clear of the rising edge, so every capture lands on a known edge. It also moves the ratio across the 1 boundary only while the output is idle or in reset.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

    localparam int SYNC_DEPTH = 2;

    function automatic int hi_cycles(input int n);
        return (n + 1) / 2;
    endfunction

    function automatic int lo_cycles(input int n);
        return n / 2;
    endfunction

endpackage

// File: rtl/clkdiv_sync.sv
module clkdiv_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic async_i,
    output logic early_o,
    output logic late_o
);
    logic [STAGES-1:0] chain_d, chain_q;

    generate
        if (STAGES > 1) begin : g_multi
            always_comb chain_d = {chain_q[STAGES-2:0], async_i};
        end else begin : g_single
            always_comb chain_d = async_i;
        end
    endgenerate

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= '0;
        else         chain_q <= chain_d;
    end

    assign early_o = chain_q[0];
    assign late_o  = chain_q[STAGES-1];
endmodule

// File: rtl/clkdiv_core.sv
module clkdiv_core #(
    parameter int MAX_DIV = 32,
    localparam int DIV_W  = $clog2(MAX_DIV + 1),
    localparam int CNT_W  = $clog2(MAX_DIV)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             en_s_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             out_o,
    output logic             run_o,
    output logic [CNT_W-1:0] cnt_o,
    output logic [DIV_W-1:0] ratio_o
);
    typedef struct packed {
        logic             run;
        logic             out;
        logic [CNT_W-1:0] cnt;
        logic [DIV_W-1:0] ratio;
    } core_state_t;

    core_state_t st_d, st_q;
    logic [DIV_W-1:0] ratio_in;
    logic [CNT_W-1:0] nxt_cnt;
    logic [DIV_W:0]   hi_len;
    logic             term;

    always_comb begin
        if (div_i == '0)                  ratio_in = DIV_W'(1);
        else if (div_i > DIV_W'(MAX_DIV)) ratio_in = DIV_W'(MAX_DIV);
        else                              ratio_in = div_i;

        term    = (st_q.cnt == CNT_W'(st_q.ratio - DIV_W'(1)));
        nxt_cnt = st_q.cnt + CNT_W'(1);
        hi_len  = ({1'b0, st_q.ratio} + (DIV_W+1)'(1)) >> 1;

        st_d = st_q;
        if (!st_q.run) begin
            st_d.ratio = ratio_in;
            st_d.cnt   = '0;
            st_d.out   = en_s_i;
            st_d.run   = en_s_i;
        end else if (term) begin
            st_d.cnt   = '0;
            st_d.ratio = ratio_in;
            st_d.out   = en_s_i;
            st_d.run   = en_s_i;
        end else begin
            st_d.cnt = nxt_cnt;
            st_d.out = ({{(DIV_W+1-CNT_W){1'b0}}, nxt_cnt} < hi_len);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.run   <= 1'b0;
            st_q.out   <= 1'b0;
            st_q.cnt   <= '0;
            st_q.ratio <= DIV_W'(1);
        end else begin
            st_q <= st_d;
        end
    end

    assign out_o   = st_q.out;
    assign run_o   = st_q.run;
    assign cnt_o   = st_q.cnt;
    assign ratio_o = st_q.ratio;
endmodule

// File: rtl/clkdiv_pass_gate.sv
module clkdiv_pass_gate (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic en_i,
    output logic gclk_o
);
    logic gate_q;

    always_latch begin
        if (!rst_ni)     gate_q = 1'b0;
        else if (!clk_i) gate_q = en_i;
    end

    assign gclk_o = clk_i & gate_q;
endmodule

// File: rtl/glitchfree_clkdiv.sv
module glitchfree_clkdiv #(
    parameter int MAX_DIV = 32,
    localparam int DIV_W  = $clog2(MAX_DIV + 1),
    localparam int CNT_W  = $clog2(MAX_DIV)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [DIV_W-1:0] div_i,
    input  logic             en_i,
    output logic             clk_o
);
    logic             en_early, en_late;
    logic             div_out, run;
    logic [CNT_W-1:0] cnt;
    logic [DIV_W-1:0] ratio;
    logic             by_one;
    logic             pass_clk;

    clkdiv_sync #(.STAGES(clkdiv_pkg::SYNC_DEPTH)) u_sync (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .async_i (en_i),
        .early_o (en_early),
        .late_o  (en_late)
    );

    clkdiv_core #(.MAX_DIV(MAX_DIV)) u_core (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .en_s_i  (en_late),
        .div_i   (div_i),
        .out_o   (div_out),
        .run_o   (run),
        .cnt_o   (cnt),
        .ratio_o (ratio)
    );

    assign by_one = (ratio == DIV_W'(1));

    clkdiv_pass_gate u_pass (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .en_i   (en_early & by_one),
        .gclk_o (pass_clk)
    );

    assign clk_o = by_one ? pass_clk : div_out;
endmodule

// File: rtl/clkdiv_checker.sv
module clkdiv_checker #(
    parameter int MAX_DIV = 32,
    localparam int DIV_W  = $clog2(MAX_DIV + 1),
    localparam int CNT_W  = $clog2(MAX_DIV)
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             en_s_i,
    input logic             run_i,
    input logic             out_i,
    input logic [CNT_W-1:0] cnt_i,
    input logic [DIV_W-1:0] ratio_i
);
    logic [DIV_W:0] hi_run_q, lo_run_q;
    logic           multi;

    assign multi = (ratio_i != DIV_W'(1));

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            hi_run_q <= '0;
            lo_run_q <= '0;
        end else begin
            hi_run_q <= (out_i && multi) ? hi_run_q + (DIV_W+1)'(1) : '0;
            lo_run_q <= (!out_i && run_i && multi) ? lo_run_q + (DIV_W+1)'(1) : '0;
        end
    end

    always @(posedge clk_i) begin
        if (!rst_ni) begin
            p_reset_quiet_r1: assert (!out_i && !run_i)
                else $error("output active during reset");
        end
    end

    p_high_whole_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($fell(out_i) && $past(ratio_i) != DIV_W'(1))
        |-> hi_run_q == (DIV_W+1)'(clkdiv_pkg::hi_cycles(int'($past(ratio_i)))));

    p_low_whole_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($rose(out_i) && $past(run_i) && $past(ratio_i) != DIV_W'(1))
        |-> lo_run_q == (DIV_W+1)'(clkdiv_pkg::lo_cycles(int'($past(ratio_i)))));

    p_start_needs_enable_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(run_i) |-> $past(en_s_i));

    p_first_from_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(run_i) |-> (cnt_i == '0 && out_i));

    p_ratio_held_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (run_i && cnt_i != CNT_W'(ratio_i - DIV_W'(1))) |=> $stable(ratio_i));
endmodule

bind glitchfree_clkdiv clkdiv_checker #(.MAX_DIV(MAX_DIV)) u_chk (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_s_i  (en_late),
    .run_i   (run),
    .out_i   (div_out),
    .cnt_i   (cnt),
    .ratio_i (ratio)
);

// File: tb/glitchfree_clkdiv_bench.sv
module glitchfree_clkdiv_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] div = 6'd4;
    logic       en = 1'b0;
    logic       clk_o;

    int checks = 0;
    int errors = 0;
    logic hs [0:127];
    logic ls [0:127];

    always #5 clk = ~clk;

    glitchfree_clkdiv u_glitchfree_clkdiv (
        .clk_i (clk), .rst_ni (rst_n), .div_i (div), .en_i (en), .clk_o (clk_o)
    );

    // hs[i]: output just after rising edge i+1; ls[i]: just after the following falling edge
    task automatic capture(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #2; hs[i] = clk_o;
            @(negedge clk); #2; ls[i] = clk_o;
        end
    endtask

    task automatic report(input string req, input int bad, input int idx, input logic act, input logic exp);
        checks++;
        if (bad != 0) begin
            errors++;
            $display("FAIL %s edge %0d actual %0b expected %0b", req, idx + 1, act, exp);
        end
    endtask

    // expected train: period of n starting at edge st, ceil(n/2) high
    task automatic check_train(input string req, input int n_edges, input int st, input int n);
        int bad = 0; int idx = 0; logic a = 0; logic e = 0;
        for (int i = 0; i < n_edges; i++) begin
            int rel = i + 1 - st;
            logic ex = (rel >= 0) && ((rel % n) < (n + 1) / 2);
            if (hs[i] !== ex || ls[i] !== ex) begin
                if (bad == 0) begin idx = i; a = hs[i]; e = ex; end
                bad++;
            end
        end
        report(req, bad, idx, a, e);
    endtask

    task automatic check_seq(input string req, input int n_edges, input logic [31:0] pat, input logic low_zero);
        int bad = 0; int idx = 0; logic a = 0; logic e = 0;
        for (int i = 0; i < n_edges; i++) begin
            logic ex = (i < 32) ? pat[i] : 1'b0;
            logic lx = low_zero ? 1'b0 : ex;
            if (hs[i] !== ex || ls[i] !== lx) begin
                if (bad == 0) begin idx = i; a = (hs[i] !== ex) ? hs[i] : ls[i]; e = (hs[i] !== ex) ? ex : lx; end
                bad++;
            end
        end
        report(req, bad, idx, a, e);
    endtask

    task automatic do_reset();
        en = 1'b0;
        rst_n = 1'b0;
        capture(3);
        rst_n = 1'b1;
        capture(2);
    endtask

    task automatic t_reset();
        div = 6'd4; en = 1'b1; rst_n = 1'b0;
        capture(4);
        check_seq("R1 low in reset", 4, 32'h0, 1'b0);
        rst_n = 1'b1;
        capture(12);
        check_train("R1 R3 start after release", 12, 3, 4);
    endtask

    task automatic t_ratio(input int n, input int edges);
        div = 6'(n);
        do_reset();
        en = 1'b1;
        capture(edges);
        check_train("R2 R3 R4 divided waveform", edges, 3, n);
    endtask

    task automatic t_drop_high();
        div = 6'd4;
        do_reset();
        en = 1'b1;
        capture(3);
        check_train("R4 first pulse", 3, 3, 4);
        en = 1'b0;
        capture(12);
        check_seq("R5 drop while high", 12, 32'h1, 1'b0);
    endtask

    task automatic t_drop_low();
        div = 6'd4;
        do_reset();
        en = 1'b1;
        capture(5);
        en = 1'b0;
        capture(12);
        check_seq("R6 drop while low", 12, 32'h6, 1'b0);
    endtask

    task automatic t_change();
        div = 6'd4;
        do_reset();
        en = 1'b1;
        capture(3);
        div = 6'd2;
        capture(10);
        check_seq("R7 change at terminal", 10, 32'h2A9, 1'b0);
    endtask

    task automatic t_by_one(input logic [5:0] d, input string req);
        div = d;
        do_reset();
        en = 1'b1;
        capture(6);
        check_seq(req, 6, 32'h3E, 1'b1);
        en = 1'b0;
        capture(6);
        check_seq("R8 pass-through stop", 6, 32'h1, 1'b1);
    endtask

    initial begin
        t_reset();
        t_ratio(4, 14);
        t_ratio(5, 20);
        t_ratio(2, 10);
        t_ratio(3, 12);
        t_ratio(32, 70);
        t_drop_high();
        t_drop_low();
        t_change();
        t_by_one(6'd1, "R8 pass-through start");
        t_by_one(6'd0, "R7 R8 zero ratio acts as one");
        div = 6'd40;
        do_reset();
        en = 1'b1;
        capture(70);
        check_train("R7 ratio above range clamps", 70, 3, 32);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #2000000;
        checks++;
        errors++;
        $display("FAIL watchdog expired actual running expected finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule